// File: doc/BRIEF.md
# Safe/Unsafe Split Store Buffer

This unit holds retired stores for a sequentially consistent core and splits them into two in-order queues by access class. An access counts as safe when its decode-time static flag or its translation-time page flag is set. Safe stores go to a safe queue and all other stores go to an unsafe queue. Each queue has its own in-order write port toward the cache, so a long miss in one queue does not hold up the other.

Loads are checked against their own class only. A safe load may perform at once and takes forwarded data from the youngest matching entry in the safe queue. An unsafe load is held back until the unsafe queue is empty. Classification can change for a short time, so a store whose address is still pending in the other queue is stalled until that entry has left. A store then never overtakes an earlier store to the same address. When a page changes from safe to unsafe, a drain command stops all new stores and loads until both queues are empty.

Top module: `dual_class_store_buffer`

## Requirements
- R1: An access is classed safe when `*_static_safe` or `*_page_safe` is 1, and unsafe only when both are 0.
- R2: An accepted safe store is written out only on the `sw_*` port and an accepted unsafe store only on the `uw_*` port.
- R3: Each queue presents its entries on its write port in the order they were accepted, and `sw_valid`/`uw_valid` are 0 during and right after reset.
- R4: When `ld_valid` is 1, `ld_fwd_hit` is 1 exactly when the load's own-class queue holds an entry with address `ld_addr`. `ld_fwd_data` is then the data of the youngest such entry. The other queue is never searched.
- R5: `ld_ready` is 0 for an unsafe load while the unsafe queue holds any entry. A safe load is not held by the unsafe queue.
- R6: `st_ready` is 0 while the opposite-class queue holds an entry with address `st_addr`.
- R7: `safe_full`/`unsafe_full` are 1 when their queue holds DEPTH entries, and `st_ready` is 0 for a store aimed at a full queue.
- R8: `busy` rises the cycle after `drain_req`, stays 1 while either queue holds an entry, and falls the cycle after both are seen empty. While `drain_req` or `busy` is 1, `st_ready` and `ld_ready` are 0.
- R9: A write port holds `*_valid`, address and data unchanged while its `*_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Retiring store present |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_static_safe | input | 1 | Decode-time safe flag of the store |
| st_page_safe | input | 1 | Page-type safe flag of the store |
| st_ready | output | 1 | Store accepted this cycle when valid |
| ld_valid | input | 1 | Load present |
| ld_addr | input | AW | Load address |
| ld_static_safe | input | 1 | Decode-time safe flag of the load |
| ld_page_safe | input | 1 | Page-type safe flag of the load |
| ld_ready | output | 1 | Load may perform this cycle |
| ld_fwd_hit | output | 1 | Same-class queue holds a matching store |
| ld_fwd_data | output | DW | Data of the youngest matching store |
| drain_req | input | 1 | Page reclassified; drain both queues |
| busy | output | 1 | Drain in progress |
| safe_full | output | 1 | Safe queue full |
| unsafe_full | output | 1 | Unsafe queue full |
| sw_valid | output | 1 | Safe queue head valid |
| sw_addr | output | AW | Safe queue head address |
| sw_data | output | DW | Safe queue head data |
| sw_ready | input | 1 | Cache takes the safe head |
| uw_valid | output | 1 | Unsafe queue head valid |
| uw_addr | output | AW | Unsafe queue head address |
| uw_data | output | DW | Unsafe queue head data |
| uw_ready | input | 1 | Cache takes the unsafe head |

## Verification
The bench builds the unit with DEPTH=4, AW=8 and DW=16. Four entries let random traffic hit both full flags often. An 8-bit address drawn from a small pool of values makes same-address matches common. That covers forwarding from the youngest of several matching entries, stalls on cross-class conflicts, and unsafe loads waiting behind stores. Write-port back-pressure and drain commands come at random, so drains often start with both queues partly filled.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic {
        KIND_UNSAFE = 1'b0,
        KIND_SAFE   = 1'b1
    } buf_kind_e;

    localparam int NUM_KINDS = 2;

    function automatic buf_kind_e classify(input logic static_safe, input logic page_safe);
        return (static_safe || page_safe) ? KIND_SAFE : KIND_UNSAFE;
    endfunction

    function automatic buf_kind_e other_kind(input buf_kind_e k);
        return (k == KIND_SAFE) ? KIND_UNSAFE : KIND_SAFE;
    endfunction

endpackage

// File: rtl/sbuf_queue.sv
module sbuf_queue #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          head_valid,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          full,
    output logic          empty,
    input  logic [AW-1:0] fwd_addr,
    output logic          fwd_hit,
    output logic [DW-1:0] fwd_data,
    input  logic [AW-1:0] cfl_addr,
    output logic          cfl_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign empty      = (count == '0);
    assign full       = (int'(count) == DEPTH);
    assign head_valid = !empty;
    assign head_addr  = addr_q[rd_ptr];
    assign head_data  = data_q[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                addr_q[wr_ptr] <= push_addr;
                data_q[wr_ptr] <= push_data;
                wr_ptr         <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Walk from oldest to youngest so the last match is the youngest.
    always_comb begin
        fwd_hit  = 1'b0;
        fwd_data = '0;
        cfl_hit  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [PTR_W-1:0] idx;
            idx = PTR_W'((int'(rd_ptr) + i) % DEPTH);
            if (i < int'(count)) begin
                if (addr_q[idx] == fwd_addr) begin
                    fwd_hit  = 1'b1;
                    fwd_data = data_q[idx];
                end
                if (addr_q[idx] == cfl_addr) cfl_hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbuf_drain_ctrl.sv
module sbuf_drain_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic drain_req,
    input  logic all_empty,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst)               busy <= 1'b0;
        else if (drain_req)    busy <= 1'b1;
        else if (all_empty)    busy <= 1'b0;
    end
endmodule

// File: rtl/dual_class_store_buffer.sv
module dual_class_store_buffer
    import sbuf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          st_static_safe,
    input  logic          st_page_safe,
    output logic          st_ready,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_static_safe,
    input  logic          ld_page_safe,
    output logic          ld_ready,
    output logic          ld_fwd_hit,
    output logic [DW-1:0] ld_fwd_data,
    input  logic          drain_req,
    output logic          busy,
    output logic          safe_full,
    output logic          unsafe_full,
    output logic          sw_valid,
    output logic [AW-1:0] sw_addr,
    output logic [DW-1:0] sw_data,
    input  logic          sw_ready,
    output logic          uw_valid,
    output logic [AW-1:0] uw_addr,
    output logic [DW-1:0] uw_data,
    input  logic          uw_ready
);
    buf_kind_e st_kind, ld_kind, st_opp;
    logic      hold, st_fire;

    logic [NUM_KINDS-1:0] buf_push, buf_pop, buf_full, buf_empty;
    logic [NUM_KINDS-1:0] buf_hv, buf_fwd_hit, buf_cfl_hit, port_ready;
    logic [AW-1:0]        buf_head_addr [NUM_KINDS];
    logic [DW-1:0]        buf_head_data [NUM_KINDS];
    logic [DW-1:0]        buf_fwd_data  [NUM_KINDS];

    assign st_kind = classify(st_static_safe, st_page_safe);
    assign ld_kind = classify(ld_static_safe, ld_page_safe);
    assign st_opp  = other_kind(st_kind);
    assign hold    = busy || drain_req;

    assign port_ready[KIND_SAFE]   = sw_ready;
    assign port_ready[KIND_UNSAFE] = uw_ready;

    assign st_ready = !hold && !buf_full[st_kind] && !buf_cfl_hit[st_opp];
    assign st_fire  = st_valid && st_ready;

    assign ld_ready    = ld_valid && !hold &&
                         ((ld_kind == KIND_SAFE) || buf_empty[KIND_UNSAFE]);
    assign ld_fwd_hit  = ld_valid && buf_fwd_hit[ld_kind];
    assign ld_fwd_data = ld_fwd_hit ? buf_fwd_data[ld_kind] : '0;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_queue
        assign buf_push[k] = st_fire && (int'(st_kind) == k);
        assign buf_pop[k]  = buf_hv[k] && port_ready[k];

        sbuf_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_queue (
            .clk        (clk),
            .rst        (rst),
            .push       (buf_push[k]),
            .push_addr  (st_addr),
            .push_data  (st_data),
            .pop        (buf_pop[k]),
            .head_valid (buf_hv[k]),
            .head_addr  (buf_head_addr[k]),
            .head_data  (buf_head_data[k]),
            .full       (buf_full[k]),
            .empty      (buf_empty[k]),
            .fwd_addr   (ld_addr),
            .fwd_hit    (buf_fwd_hit[k]),
            .fwd_data   (buf_fwd_data[k]),
            .cfl_addr   (st_addr),
            .cfl_hit    (buf_cfl_hit[k])
        );
    end

    assign sw_valid    = buf_hv[KIND_SAFE];
    assign sw_addr     = buf_head_addr[KIND_SAFE];
    assign sw_data     = buf_head_data[KIND_SAFE];
    assign uw_valid    = buf_hv[KIND_UNSAFE];
    assign uw_addr     = buf_head_addr[KIND_UNSAFE];
    assign uw_data     = buf_head_data[KIND_UNSAFE];
    assign safe_full   = buf_full[KIND_SAFE];
    assign unsafe_full = buf_full[KIND_UNSAFE];

    sbuf_drain_ctrl i_drain (
        .clk       (clk),
        .rst       (rst),
        .drain_req (drain_req),
        .all_empty (&buf_empty),
        .busy      (busy)
    );
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          st_valid,
    input logic          st_ready,
    input logic          st_static_safe,
    input logic          st_page_safe,
    input logic          ld_valid,
    input logic          ld_ready,
    input logic          ld_static_safe,
    input logic          ld_page_safe,
    input logic          drain_req,
    input logic          busy,
    input logic          safe_full,
    input logic          unsafe_full,
    input logic          unsafe_empty,
    input logic          all_empty,
    input logic          sw_valid,
    input logic [AW-1:0] sw_addr,
    input logic [DW-1:0] sw_data,
    input logic          sw_ready,
    input logic          uw_valid,
    input logic [AW-1:0] uw_addr,
    input logic [DW-1:0] uw_data,
    input logic          uw_ready
);
    a_r5_unsafe_load_waits: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_ready && !ld_static_safe && !ld_page_safe) |-> unsafe_empty);

    a_r6_heads_disjoint: assert property (@(posedge clk) disable iff (rst)
        (sw_valid && uw_valid) |-> (sw_addr != uw_addr));

    a_r7_safe_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (safe_full && (st_static_safe || st_page_safe)) |-> !st_ready);

    a_r7_unsafe_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (unsafe_full && !st_static_safe && !st_page_safe) |-> !st_ready);

    a_r8_drain_raises_busy: assert property (@(posedge clk) disable iff (rst)
        drain_req |=> busy);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !all_empty) |=> busy);

    a_r8_no_store_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!st_ready && !ld_ready));

    a_r9_safe_port_stable: assert property (@(posedge clk) disable iff (rst)
        (sw_valid && !sw_ready) |=> (sw_valid && $stable(sw_addr) && $stable(sw_data)));

    a_r9_unsafe_port_stable: assert property (@(posedge clk) disable iff (rst)
        (uw_valid && !uw_ready) |=> (uw_valid && $stable(uw_addr) && $stable(uw_data)));

    a_r3_idle_after_reset: assert property (@(posedge clk)
        rst |=> (!sw_valid && !uw_valid && !busy));
endmodule

bind dual_class_store_buffer sbuf_checker #(.AW(AW), .DW(DW)) i_sbuf_checker (
    .clk            (clk),
    .rst            (rst),
    .st_valid       (st_valid),
    .st_ready       (st_ready),
    .st_static_safe (st_static_safe),
    .st_page_safe   (st_page_safe),
    .ld_valid       (ld_valid),
    .ld_ready       (ld_ready),
    .ld_static_safe (ld_static_safe),
    .ld_page_safe   (ld_page_safe),
    .drain_req      (drain_req),
    .busy           (busy),
    .safe_full      (safe_full),
    .unsafe_full    (unsafe_full),
    .unsafe_empty   (buf_empty[0]),
    .all_empty      (&buf_empty),
    .sw_valid       (sw_valid),
    .sw_addr        (sw_addr),
    .sw_data        (sw_data),
    .sw_ready       (sw_ready),
    .uw_valid       (uw_valid),
    .uw_addr        (uw_addr),
    .uw_data        (uw_data),
    .uw_ready       (uw_ready)
);

// File: tb/test_dual_class_store_buffer.sv
module test_dual_class_store_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 4;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } ent_t;

    logic clk = 0, rst = 1;
    logic st_valid = 0, st_static_safe = 0, st_page_safe = 0;
    logic [AW-1:0] st_addr = 0;
    logic [DW-1:0] st_data = 0;
    logic ld_valid = 0, ld_static_safe = 0, ld_page_safe = 0;
    logic [AW-1:0] ld_addr = 0;
    logic drain_req = 0, sw_ready = 0, uw_ready = 0;
    logic st_ready, ld_ready, ld_fwd_hit, busy, safe_full, unsafe_full;
    logic [DW-1:0] ld_fwd_data, sw_data, uw_data;
    logic sw_valid, uw_valid;
    logic [AW-1:0] sw_addr, uw_addr;

    int checks = 0, failures = 0;
    ent_t sq[$], uq[$];
    bit busy_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_class_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_dual_class_store_buffer (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_static_safe(st_static_safe), .st_page_safe(st_page_safe), .st_ready(st_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_static_safe(ld_static_safe), .ld_page_safe(ld_page_safe),
        .ld_ready(ld_ready), .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data),
        .drain_req(drain_req), .busy(busy),
        .safe_full(safe_full), .unsafe_full(unsafe_full),
        .sw_valid(sw_valid), .sw_addr(sw_addr), .sw_data(sw_data), .sw_ready(sw_ready),
        .uw_valid(uw_valid), .uw_addr(uw_addr), .uw_data(uw_data), .uw_ready(uw_ready)
    );

    task automatic cmp(input string req, input string name, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, name, act, exp, $time);
        end
    endtask

    function automatic bit in_q(ref ent_t q[$], input logic [AW-1:0] a);
        foreach (q[i]) if (q[i].a == a) return 1;
        return 0;
    endfunction

    // Compare all outputs against the model, then advance the model one edge.
    task automatic step();
        bit st_safe, ld_safe, hold, conflict, exp_st_rdy, exp_ld_rdy, exp_hit, empty_both;
        logic [DW-1:0] exp_fd;
        #1;
        st_safe = st_static_safe | st_page_safe;      // R1
        ld_safe = ld_static_safe | ld_page_safe;
        hold = busy_m | drain_req;
        conflict = st_safe ? in_q(uq, st_addr) : in_q(sq, st_addr);
        exp_st_rdy = !hold && !conflict && (st_safe ? sq.size() < DEPTH : uq.size() < DEPTH);
        exp_ld_rdy = ld_valid && !hold && (ld_safe || uq.size() == 0);
        exp_hit = 0; exp_fd = '0;
        if (ld_valid) begin
            if (ld_safe) begin
                foreach (sq[i]) if (sq[i].a == ld_addr) begin exp_hit = 1; exp_fd = sq[i].d; end
            end else begin
                foreach (uq[i]) if (uq[i].a == ld_addr) begin exp_hit = 1; exp_fd = uq[i].d; end
            end
        end
        cmp("R1 R6 R7 R8", "st_ready", st_ready, exp_st_rdy);
        cmp("R5 R8", "ld_ready", ld_ready, exp_ld_rdy);
        cmp("R4", "ld_fwd_hit", ld_fwd_hit, exp_hit);
        if (exp_hit) cmp("R4", "ld_fwd_data", ld_fwd_data, exp_fd);
        cmp("R7", "safe_full", safe_full, sq.size() == DEPTH);
        cmp("R7", "unsafe_full", unsafe_full, uq.size() == DEPTH);
        cmp("R8", "busy", busy, busy_m);
        cmp("R1 R2 R3", "sw_valid", sw_valid, sq.size() > 0);
        cmp("R2 R3", "uw_valid", uw_valid, uq.size() > 0);
        if (sq.size() > 0) begin
            cmp("R2 R3 R9", "sw_addr", sw_addr, sq[0].a);
            cmp("R2 R3 R9", "sw_data", sw_data, sq[0].d);
        end
        if (uq.size() > 0) begin
            cmp("R2 R3 R9", "uw_addr", uw_addr, uq[0].a);
            cmp("R2 R3 R9", "uw_data", uw_data, uq[0].d);
        end
        empty_both = (sq.size() == 0) && (uq.size() == 0);
        @(posedge clk);
        if (sq.size() > 0 && sw_ready) void'(sq.pop_front());
        if (uq.size() > 0 && uw_ready) void'(uq.pop_front());
        if (st_valid && exp_st_rdy) begin
            if (st_safe) sq.push_back({st_addr, st_data});
            else         uq.push_back({st_addr, st_data});
        end
        if (drain_req) busy_m = 1;
        else if (empty_both) busy_m = 0;
        @(negedge clk);
    endtask

    task automatic put_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s, input logic p);
        st_valid = 1; st_addr = a; st_data = d; st_static_safe = s; st_page_safe = p;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset state
        cmp("R3", "sw_valid_reset", sw_valid, 0);
        cmp("R3", "uw_valid_reset", uw_valid, 0);
        cmp("R8", "busy_reset", busy, 0);
        rst = 0;

        // R1: static-only and page-only both land in the safe queue, held by sw_ready=0
        put_store(8'h05, 16'h1111, 1, 0); step();
        put_store(8'h06, 16'h2222, 0, 1); step();
        put_store(8'h07, 16'h3333, 0, 0); step();   // unsafe
        put_store(8'h05, 16'h4444, 1, 1); step();   // second safe entry for 0x05
        st_valid = 0;
        // R4: youngest match in safe queue; unsafe entry 0x07 invisible to safe load
        ld_valid = 1; ld_addr = 8'h05; ld_static_safe = 1; step();
        ld_addr = 8'h07; step();
        // R5: unsafe load stalls while unsafe queue is not empty
        ld_static_safe = 0; ld_page_safe = 0; step();
        ld_valid = 0;
        // R6: unsafe store to an address pending in the safe queue stalls
        put_store(8'h06, 16'h5555, 0, 0); step(); step();
        // R7: fill the safe queue
        put_store(8'h10, 16'h6666, 1, 0); step();
        put_store(8'h11, 16'h7777, 1, 0); step();
        st_valid = 0;
        // R9 and R3: release the safe port and let it drain in order
        sw_ready = 1; step(); step(); step();
        // R8: drain command with unsafe queue still occupied
        drain_req = 1; step(); drain_req = 0;
        put_store(8'h20, 16'h8888, 1, 0); step(); step();
        uw_ready = 1; st_valid = 0;
        repeat (4) step();

        // Random traffic with a small address pool
        for (int n = 0; n < 4000; n++) begin
            st_valid = ($urandom_range(0, 3) != 0);
            st_addr = AW'($urandom_range(0, 7));
            st_data = DW'($urandom());
            st_static_safe = $urandom_range(0, 3) == 0;
            st_page_safe = $urandom_range(0, 3) == 0;
            ld_valid = $urandom_range(0, 1);
            ld_addr = AW'($urandom_range(0, 7));
            ld_static_safe = $urandom_range(0, 1);
            ld_page_safe = $urandom_range(0, 3) == 0;
            drain_req = ($urandom_range(0, 60) == 0);
            sw_ready = ($urandom_range(0, 2) == 0);
            uw_ready = ($urandom_range(0, 2) == 0);
            step();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule